// File: doc/BRIEF.md
# Thread Frame Allocator with Input Counters

This block hands out slots from a pool of equally sized thread frames and takes them back. A requester asking for a frame supplies the entry address of the thread and the number of inputs that thread must receive before it may run. The block pops a free slot number from a last-in, first-out list and records the entry address as header word 0 and the input count as header word 1 of that slot. It then returns the slot number as the frame pointer. Returning a frame pushes its number back on the list. A frame is normally returned once its inputs have been copied into a register set.

Each input written into a frame lowers that frame's count by one. The write that takes the count from one to zero produces a single enable event, which carries the frame pointer and the stored entry address. Every allocate and free takes a fixed four cycles. A small sequencer with three states governs them. `ST_IDLE` waits for a request and goes to `ST_WAIT` when it accepts one. `ST_WAIT` counts out the latency and moves to `ST_DONE` after the last wait cycle. `ST_DONE` presents the result for one cycle and returns to `ST_IDLE`.

Top module: `frame_alloc_sync`

## Requirements
- R1: After reset all frames are free, all done, stall and enable outputs are low, and successive allocations return frame pointers 0, 1, 2, ... in ascending order.
- R2: An allocate request is held high until `alloc_done`. If the request is presented in cycle c while the block is idle, `alloc_done` is high for exactly one cycle, in cycle c+3, with `alloc_fp` holding the popped frame.
- R3: Frames are reused last-in, first-out: the next allocation returns the most recently freed frame.
- R4: A free request follows the same timing as R2, with `free_done` high in cycle c+3. When the frame was in use, its pointer is pushed back and `free_err` stays low.
- R5: Freeing a frame that is already free asserts `free_err` together with `free_done` and leaves the free list unchanged. The following allocations return the same pointers they would have returned without that request.
- R6: While no frame is free, a held allocate request raises `alloc_stall` and does not complete. It completes once a frame becomes free.
- R7: When an allocate and a valid free are accepted in the same cycle, the free is applied first. `alloc_fp` then equals the freed pointer, and both done outputs rise in the same cycle.
- R8: On allocation, header word 0 receives `alloc_ip` and header word 1 receives `alloc_cnt`. Each cycle with `st_valid` lowers that frame's count by one. The store that lowers it from 1 to 0 makes `en_valid` high in the next cycle, with `en_fp` equal to the frame and `en_ip` equal to its entry address. Earlier stores make no enable.
- R9: A store to a frame whose count is already zero is ignored: it produces no enable, and a later allocation still behaves as in R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| alloc_req | input | 1 | Allocate request, held until done |
| alloc_ip | input | IP_W | Entry address of the new thread |
| alloc_cnt | input | CNT_W | Inputs the thread waits for |
| alloc_done | output | 1 | One-cycle completion of an allocate |
| alloc_fp | output | FP_W | Allocated frame pointer, valid with alloc_done |
| alloc_stall | output | 1 | Allocate held off because the pool is empty |
| free_req | input | 1 | Free request, held until done |
| free_fp | input | FP_W | Frame to return |
| free_done | output | 1 | One-cycle completion of a free |
| free_err | output | 1 | The returned frame was already free |
| st_valid | input | 1 | An input is being written into a frame |
| st_fp | input | FP_W | Frame receiving the input |
| en_valid | output | 1 | A thread became enabled |
| en_fp | output | FP_W | Frame of the enabled thread |
| en_ip | output | IP_W | Entry address of the enabled thread |

## Verification
The assertions assume that requesters hold `alloc_req` and `free_req` steady from the cycle they are raised until the matching done, and that a store never targets the slot being allocated in the same cycle. The stimulus drives one operation at a time, or a deliberate allocate/free pair, and releases each request in the cycle its done is seen. Stores are issued only between operations. Double frees and stores to exhausted counters are generated on purpose, since the design must absorb them without breaking its stack invariants.

// File: rtl/fa_pkg.sv
package fa_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_DONE = 2'd2
    } fa_state_e;
endpackage

// File: rtl/fa_stack.sv
module fa_stack #(
    parameter int N    = 32,
    parameter int FP_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push_en,
    input  logic [FP_W-1:0] push_idx,
    input  logic            pop_en,
    output logic [FP_W-1:0] pop_idx,
    output logic            empty,
    input  logic [FP_W-1:0] chk_idx,
    output logic            chk_free
);
    localparam int SP_W = $clog2(N + 1);

    logic [FP_W-1:0] stk [N];
    logic [SP_W-1:0] sp;
    logic [N-1:0]    free_map;
    logic [FP_W-1:0] top_ptr;
    logic [FP_W-1:0] top_idx;

    assign top_ptr  = FP_W'(sp - SP_W'(1));
    assign top_idx  = (sp == '0) ? '0 : stk[top_ptr];
    assign empty    = (sp == '0);
    assign pop_idx  = push_en ? push_idx : top_idx;
    assign chk_free = free_map[chk_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                stk[i] <= FP_W'(N - 1 - i);
            end
            sp       <= SP_W'(N);
            free_map <= '1;
        end else begin
            unique case ({push_en, pop_en})
                2'b10: begin
                    stk[FP_W'(sp)]     <= push_idx;
                    sp                 <= sp + SP_W'(1);
                    free_map[push_idx] <= 1'b1;
                end
                2'b01: begin
                    sp                <= sp - SP_W'(1);
                    free_map[top_idx] <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (push_en && !pop_en) |-> (sp < SP_W'(N)));

    p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_en && !push_en) |-> (sp != '0));

    p_pop_is_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_en && !push_en) |-> free_map[top_idx]);
endmodule

// File: rtl/fa_sync.sv
module fa_sync #(
    parameter int N     = 32,
    parameter int FP_W  = 5,
    parameter int IP_W  = 16,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [FP_W-1:0]  wr_idx,
    input  logic [IP_W-1:0]  wr_ip,
    input  logic [CNT_W-1:0] wr_cnt,
    input  logic             st_en,
    input  logic [FP_W-1:0]  st_idx,
    output logic             en_valid,
    output logic [FP_W-1:0]  en_fp,
    output logic [IP_W-1:0]  en_ip
);
    logic [IP_W-1:0]  hdr_ip  [N];
    logic [CNT_W-1:0] hdr_cnt [N];
    logic             hit;
    logic             last;

    assign hit  = st_en && !(wr_en && (wr_idx == st_idx)) && (hdr_cnt[st_idx] != '0);
    assign last = hit && (hdr_cnt[st_idx] == CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                hdr_ip[i]  <= '0;
                hdr_cnt[i] <= '0;
            end
            en_valid <= 1'b0;
            en_fp    <= '0;
            en_ip    <= '0;
        end else begin
            en_valid <= last;
            en_fp    <= st_idx;
            en_ip    <= hdr_ip[st_idx];
            if (wr_en) begin
                hdr_ip[wr_idx]  <= wr_ip;
                hdr_cnt[wr_idx] <= wr_cnt;
            end
            if (hit) begin
                hdr_cnt[st_idx] <= hdr_cnt[st_idx] - CNT_W'(1);
            end
        end
    end

    p_enable_after_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
        en_valid |-> $past(st_en));

    p_single_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en_valid && $past(st_en) && st_en && (st_idx == $past(st_idx)) && !$past(wr_en)) |=> !en_valid);
endmodule

// File: rtl/frame_alloc_sync.sv
module frame_alloc_sync
    import fa_pkg::*;
#(
    parameter int NUM_FRAMES = 32,
    parameter int IP_W       = 16,
    parameter int CNT_W      = 4,
    parameter int OP_LAT     = 4,
    localparam int FP_W      = $clog2(NUM_FRAMES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_req,
    input  logic [IP_W-1:0]  alloc_ip,
    input  logic [CNT_W-1:0] alloc_cnt,
    output logic             alloc_done,
    output logic [FP_W-1:0]  alloc_fp,
    output logic             alloc_stall,
    input  logic             free_req,
    input  logic [FP_W-1:0]  free_fp,
    output logic             free_done,
    output logic             free_err,
    input  logic             st_valid,
    input  logic [FP_W-1:0]  st_fp,
    output logic             en_valid,
    output logic [FP_W-1:0]  en_fp,
    output logic [IP_W-1:0]  en_ip
);
    localparam int WC_W = (OP_LAT > 4) ? $clog2(OP_LAT) : 2;
    localparam int AG_W = $clog2(OP_LAT + 1) + 1;
    localparam logic [FP_W:0] LIMIT = (FP_W + 1)'(NUM_FRAMES);

    fa_state_e       state_q, state_d;
    logic [WC_W-1:0] wait_cnt;
    logic            r_alloc, r_free, r_err;
    logic [FP_W-1:0] r_fp;

    logic            idle, in_range, free_ok, alloc_go, accept;
    logic            stk_empty, chk_free;
    logic [FP_W-1:0] pop_idx;

    assign idle     = (state_q == ST_IDLE);
    assign in_range = ({1'b0, free_fp} < LIMIT);
    assign free_ok  = idle && free_req && in_range && !chk_free;
    assign alloc_go = idle && alloc_req && (!stk_empty || free_ok);
    assign accept   = alloc_go || (idle && free_req);

    fa_stack #(.N(NUM_FRAMES), .FP_W(FP_W)) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_en  (free_ok),
        .push_idx (free_fp),
        .pop_en   (alloc_go),
        .pop_idx  (pop_idx),
        .empty    (stk_empty),
        .chk_idx  (free_fp),
        .chk_free (chk_free)
    );

    fa_sync #(.N(NUM_FRAMES), .FP_W(FP_W), .IP_W(IP_W), .CNT_W(CNT_W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (alloc_go),
        .wr_idx   (pop_idx),
        .wr_ip    (alloc_ip),
        .wr_cnt   (alloc_cnt),
        .st_en    (st_valid),
        .st_idx   (st_fp),
        .en_valid (en_valid),
        .en_fp    (en_fp),
        .en_ip    (en_ip)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_WAIT;
            ST_WAIT: if (wait_cnt == WC_W'(OP_LAT - 3)) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            wait_cnt <= '0;
            r_alloc  <= 1'b0;
            r_free   <= 1'b0;
            r_err    <= 1'b0;
            r_fp     <= '0;
        end else begin
            state_q  <= state_d;
            wait_cnt <= (state_q == ST_WAIT) ? wait_cnt + WC_W'(1) : '0;
            if (accept) begin
                r_alloc <= alloc_go;
                r_free  <= free_req;
                r_err   <= free_req && !free_ok;
                r_fp    <= pop_idx;
            end
        end
    end

    always_comb begin
        alloc_done  = (state_q == ST_DONE) && r_alloc;
        free_done   = (state_q == ST_DONE) && r_free;
        free_err    = (state_q == ST_DONE) && r_free && r_err;
        alloc_fp    = r_fp;
        alloc_stall = idle && alloc_req && !alloc_go;
    end

    logic [AG_W-1:0] op_age;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      op_age <= '0;
        else if (accept) op_age <= AG_W'(1);
        else if (!idle)  op_age <= op_age + AG_W'(1);
    end

    p_fixed_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_done || free_done) |-> (op_age == AG_W'(OP_LAT - 1)));

    p_stall_when_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_stall |-> stk_empty);

    p_fresh_reuse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_go && free_ok) |-> (pop_idx == free_fp));

    p_done_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_done || free_done) |=> !(alloc_done || free_done));
endmodule

// File: tb/frame_alloc_sync_bench.sv
module frame_alloc_sync_bench;
    localparam int N = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_req = 1'b0;
    logic [15:0] alloc_ip = '0;
    logic [3:0]  alloc_cnt = '0;
    logic        alloc_done;
    logic [4:0]  alloc_fp;
    logic        alloc_stall;
    logic        free_req = 1'b0;
    logic [4:0]  free_fp = '0;
    logic        free_done;
    logic        free_err;
    logic        st_valid = 1'b0;
    logic [4:0]  st_fp = '0;
    logic        en_valid;
    logic [4:0]  en_fp;
    logic [15:0] en_ip;

    always #4 clk = ~clk;

    frame_alloc_sync u_frame_alloc_sync (
        .clk(clk), .rst_n(rst_n),
        .alloc_req(alloc_req), .alloc_ip(alloc_ip), .alloc_cnt(alloc_cnt),
        .alloc_done(alloc_done), .alloc_fp(alloc_fp), .alloc_stall(alloc_stall),
        .free_req(free_req), .free_fp(free_fp), .free_done(free_done), .free_err(free_err),
        .st_valid(st_valid), .st_fp(st_fp),
        .en_valid(en_valid), .en_fp(en_fp), .en_ip(en_ip)
    );

    int n_chk = 0;
    int n_bad = 0;

    int m_stk [N];
    int m_sp;
    bit m_free [N];
    int m_cnt [N];
    int m_ip [N];

    int o_lat;
    bit o_ad, o_fd, o_err;
    int o_fp;

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic void m_reset();
        for (int i = 0; i < N; i++) begin
            m_stk[i] = N - 1 - i;
            m_free[i] = 1'b1;
            m_cnt[i] = 0;
            m_ip[i] = 0;
        end
        m_sp = N;
    endfunction

    function automatic int m_pop(input int ip, input int cnt);
        int idx;
        m_sp--;
        idx = m_stk[m_sp];
        m_free[idx] = 1'b0;
        m_ip[idx] = ip;
        m_cnt[idx] = cnt;
        return idx;
    endfunction

    function automatic bit m_push(input int idx);
        if (m_free[idx]) return 1'b1;
        m_stk[m_sp] = idx;
        m_sp++;
        m_free[idx] = 1'b1;
        return 1'b0;
    endfunction

    // Called just after a rising edge; returns just after a rising edge.
    task automatic run_op(input bit a, input int ip, input int cnt, input bit f, input int fp);
        alloc_req = a;
        alloc_ip = 16'(ip);
        alloc_cnt = 4'(cnt);
        free_req = f;
        free_fp = 5'(fp);
        o_lat = 0;
        o_ad = 0; o_fd = 0; o_err = 0; o_fp = -1;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            o_lat++;
            if (alloc_done || free_done) begin
                o_ad = alloc_done;
                o_fd = free_done;
                o_err = free_err;
                o_fp = int'(alloc_fp);
                break;
            end
        end
        alloc_req = 1'b0;
        free_req = 1'b0;
        @(posedge clk);
        #1;
    endtask

    task automatic do_alloc(input int ip, input int cnt, input string req);
        int exp;
        exp = m_pop(ip, cnt);
        run_op(1'b1, ip, cnt, 1'b0, 0);
        check(o_ad == 1'b1, req, "alloc_done", int'(o_ad), 1);
        check(o_fp == exp, req, "alloc_fp", o_fp, exp);
        check(o_lat == 4, "R2", "alloc latency", o_lat, 4);
    endtask

    task automatic do_free(input int fp, input string req);
        bit exp_err;
        exp_err = m_push(fp);
        run_op(1'b0, 0, 0, 1'b1, fp);
        check(o_fd == 1'b1, req, "free_done", int'(o_fd), 1);
        check(o_err == exp_err, req, "free_err", int'(o_err), int'(exp_err));
        check(o_lat == 4, "R4", "free latency", o_lat, 4);
    endtask

    task automatic do_both(input int ip, input int cnt, input int fp, input string req);
        bit exp_err;
        int exp;
        exp_err = m_push(fp);
        exp = m_pop(ip, cnt);
        run_op(1'b1, ip, cnt, 1'b1, fp);
        check(o_ad && o_fd, req, "both done same cycle", int'(o_ad) + int'(o_fd), 2);
        check(o_err == exp_err, req, "free_err", int'(o_err), int'(exp_err));
        check(o_fp == exp, req, "alloc_fp", o_fp, exp);
    endtask

    task automatic do_store(input int fp, input string req);
        bit exp_en;
        exp_en = (m_cnt[fp] == 1);
        if (m_cnt[fp] > 0) m_cnt[fp]--;
        st_valid = 1'b1;
        st_fp = 5'(fp);
        @(posedge clk);
        #1;
        st_valid = 1'b0;
        @(negedge clk);
        check(en_valid == exp_en, req, "en_valid", int'(en_valid), int'(exp_en));
        if (exp_en) begin
            check(int'(en_fp) == fp, req, "en_fp", int'(en_fp), fp);
            check(int'(en_ip) == m_ip[fp], req, "en_ip", int'(en_ip), m_ip[fp]);
        end
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int frm;
        int victim;
        bit saw;
        void'($urandom(32'd20240611));
        m_reset();
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(!alloc_done && !free_done && !en_valid && !alloc_stall, "R1", "outputs idle after reset",
              int'(alloc_done) + int'(free_done) + int'(en_valid) + int'(alloc_stall), 0);
        @(posedge clk);
        #1;

        // R1, R2: ascending pointers after reset
        do_alloc(16'h1000, 2, "R1");
        do_alloc(16'h1001, 2, "R1");
        do_alloc(16'h1002, 2, "R1");

        // R4, R3: LIFO reuse
        do_free(1, "R4");
        do_alloc(16'h2001, 1, "R3");
        do_free(2, "R4");
        do_free(0, "R4");
        do_alloc(16'h2000, 1, "R3");
        do_alloc(16'h2002, 1, "R3");

        // R5: double free of a never-used frame, then of a freed one
        do_free(9, "R5");
        do_alloc(16'h3003, 2, "R5");
        do_free(3, "R4");
        do_free(3, "R5");
        do_alloc(16'h3333, 2, "R5");
        do_alloc(16'h3334, 2, "R5");

        // R7: simultaneous allocate and free
        do_both(16'h4444, 3, 1, "R7");

        // R8: count down to enable
        frm = m_stk[m_sp - 1];
        do_alloc(16'hBEEF, 3, "R8");
        do_store(frm, "R8");
        do_store(frm, "R8");
        do_store(frm, "R8");
        // R9: further stores ignored
        do_store(frm, "R9");
        do_store(frm, "R9");
        do_store(31, "R9");
        do_alloc(16'hCAFE, 1, "R9");
        do_store(m_stk[m_sp], "R9");

        // R6: exhaust the pool then hold an allocate
        while (m_sp > 0) do_alloc(int'($urandom_range(65535)), 1, "R6");
        alloc_req = 1'b1;
        alloc_ip = 16'h5555;
        alloc_cnt = 4'd1;
        saw = 1'b0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            check(alloc_stall == 1'b1, "R6", "alloc_stall while empty", int'(alloc_stall), 1);
            if (alloc_done) saw = 1'b1;
        end
        check(!saw, "R6", "no completion while empty", int'(saw), 0);
        alloc_req = 1'b0;
        @(posedge clk);
        #1;
        victim = 17;
        do_both(16'h5555, 1, victim, "R6");
        do_free(victim, "R4");
        do_alloc(16'h5556, 1, "R6");

        // Random mix
        for (int it = 0; it < 400; it++) begin
            int sel;
            sel = int'($urandom_range(9));
            if (sel < 3 && m_sp > 0) begin
                do_alloc(int'($urandom_range(65535)), int'($urandom_range(4, 1)), "R3");
            end else if (sel < 6) begin
                do_free(int'($urandom_range(N - 1)), "R5");
            end else if (sel < 7 && m_sp > 0) begin
                do_both(int'($urandom_range(65535)), int'($urandom_range(4, 1)),
                        int'($urandom_range(N - 1)), "R7");
            end else begin
                do_store(int'($urandom_range(N - 1)), "R8");
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule